// File: doc/BRIEF.md
# PWM Event Trigger Selector

This block sits between several PWM up-down counter generators, an ADC front end and a processor interrupt line. Each generator emits one-clock pulses when its counter turns at minimum or maximum. The block picks one of up to eight such pulse lines as the conversion trigger. It can hold that trigger back by a programmable number of clock cycles before it reaches the ADC. It also produces a processor interrupt request on every n-th trigger. For example, a 100 kHz event stream with a ratio of 5 gives an interrupt rate of 20 kHz.

The interrupt is raised in one of two modes. In direct mode it fires together with the ADC trigger pulse. In acknowledge mode it waits for a pulse from the data mover saying that conversion results have been stored. The configured delay applies in both modes, so in acknowledge mode the interrupt follows the delayed conversion. Configuration is written once at start-up through a small register-write port, with the block disabled. Changing the select, ratio, delay or mode while the block is enabled is not supported.

Top module: `evt_trig_sel`

## Requirements
- R1: After reset, `adc_trig_o` and `irq_o` are low and the configuration is: disabled, direct mode, source 0, ratio 1, delay 0. Register addresses: 0 = control (bit 0 enable, bit 1 acknowledge mode), 1 = source index in bits [2:0], 2 = ratio in bits [15:0], 3 = delay in bits [9:0].
- R2: Only the event input whose index equals the source register can cause a trigger. Pulses on every other input have no effect on either output. Suggested index use: 0 = two-level min and max, 1 = two-level min, 2 = two-level max, 3 = three-level start and center, 4 = three-level start, 5 = three-level center, 6 and 7 spare.
- R3: With delay 0, `adc_trig_o` is high for exactly the one cycle after the clock edge that samples the selected event.
- R4: With delay D (1 to 1023), `adc_trig_o` goes high D cycles later than it would with delay 0, for exactly one cycle.
- R5: If a selected event arrives while a delayed trigger is still pending, the countdown restarts from that event and the earlier pending trigger is dropped.
- R6: After enable, triggers are counted from zero. Every n-th trigger (the n-th, 2n-th, ...) is interrupt-eligible, where n is the ratio register. A ratio of 0 behaves as 1.
- R7: In direct mode (control bit 1 = 0), `irq_o` is high in exactly the cycles where `adc_trig_o` is high for an eligible trigger.
- R8: In acknowledge mode (control bit 1 = 1), an eligible trigger sets a pending flag. The next `ack_in` pulse makes `irq_o` high for the cycle after the edge that samples it, and clears the flag. An `ack_in` with no pending flag is ignored. Several eligible triggers before one acknowledge give a single interrupt.
- R9: While enable is 0, both outputs stay low. Clearing enable discards any pending delayed trigger, the trigger count and the pending-interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| evt_in | input | 8 | One-cycle PWM counter event pulses, one per source |
| ack_in | input | 1 | One-cycle "conversion data written" pulse |
| adc_trig_o | output | 1 | Registered ADC conversion trigger pulse |
| irq_o | output | 1 | Registered processor interrupt pulse |

## Verification
The hardest situation to reach from the ports is an overlap of three things: a fresh selected event arriving while a delayed trigger is pending, an eligible count boundary, and an acknowledge that lands in the same cycle as a new eligible trigger. Random configurations use short delays (0 to 40 cycles) and sparse event and acknowledge traffic at comparable rates, so these overlaps occur repeatedly. A cycle-accurate bench model scores every cycle. Directed cases then cover the 1023-cycle delay limit, a retrigger at a known offset, disabling with a trigger still pending, and acknowledges sent with no pending flag.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;

  // Register addresses of the configuration write port
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_SEL   = 1;
  localparam int unsigned REG_RATIO = 2;
  localparam int unsigned REG_DELAY = 3;

  // Control register bit positions
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;

  typedef enum logic {
    IRQ_DIRECT = 1'b0,
    IRQ_ON_ACK = 1'b1
  } irq_mode_e;

endpackage

// File: rtl/evt_trig_cfg.sv
module evt_trig_cfg
  import evt_trig_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned DLY_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               en_o,
  output irq_mode_e          mode_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [DLY_W-1:0]   dly_o
);

  logic hit_ctrl, hit_sel, hit_ratio, hit_dly;
  logic unused_wdata;

  assign hit_ctrl  = we && (addr == ADDR_W'(REG_CTRL));
  assign hit_sel   = we && (addr == ADDR_W'(REG_SEL));
  assign hit_ratio = we && (addr == ADDR_W'(REG_RATIO));
  assign hit_dly   = we && (addr == ADDR_W'(REG_DELAY));

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      mode_o  <= IRQ_DIRECT;
      sel_o   <= '0;
      ratio_o <= RATIO_W'(1);
      dly_o   <= '0;
    end else begin
      if (hit_ctrl) begin
        en_o   <= wdata[CTRL_EN_BIT];
        mode_o <= irq_mode_e'(wdata[CTRL_MODE_BIT]);
      end
      if (hit_sel)   sel_o   <= wdata[SEL_W-1:0];
      if (hit_ratio) ratio_o <= wdata[RATIO_W-1:0];
      if (hit_dly)   dly_o   <= wdata[DLY_W-1:0];
    end
  end

endmodule

// File: rtl/evt_trig_srcsel.sv
module evt_trig_srcsel #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               en,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               evt_o
);

  logic [NUM_SRC-1:0] match;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
    assign match[i] = evt_in[i] && (sel == SEL_W'(i));
  end

  assign evt_o = en && (|match);

endmodule

// File: rtl/evt_trig_delay.sv
module evt_trig_delay #(
  parameter int unsigned DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             evt,
  input  logic [DLY_W-1:0] dly,
  output logic             fire_o
);

  logic [DLY_W-1:0] left_q;
  logic             pend_q;
  logic             expire;

  assign expire = pend_q && (left_q == DLY_W'(1));

  // A fresh event wins over an expiring older one (restart semantics)
  always_comb begin
    if (dly == '0) fire_o = evt;
    else           fire_o = expire && !evt;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      left_q <= '0;
      pend_q <= 1'b0;
    end else if (evt) begin
      left_q <= dly;
      pend_q <= (dly != '0);
    end else if (pend_q) begin
      left_q <= left_q - DLY_W'(1);
      pend_q <= !expire;
    end
  end

endmodule

// File: rtl/evt_trig_decim.sv
module evt_trig_decim
  import evt_trig_pkg::*;
#(
  parameter int unsigned RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  irq_mode_e          mode,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               fire,
  input  logic               ack,
  output logic               irq_o
);

  logic [RATIO_W-1:0] n_eff;
  logic [RATIO_W-1:0] cnt_q;
  logic               flag_q;
  logic               last;

  assign n_eff = (ratio == '0) ? RATIO_W'(1) : ratio;
  assign last  = fire && (cnt_q == n_eff - RATIO_W'(1));

  always_comb begin
    if (mode == IRQ_DIRECT) irq_o = last;
    else                    irq_o = ack && flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (fire) cnt_q <= last ? '0 : cnt_q + RATIO_W'(1);
      flag_q <= (mode == IRQ_ON_ACK) && ((flag_q && !ack) || last);
    end
  end

endmodule

// File: rtl/evt_trig_sel.sv
module evt_trig_sel
  import evt_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned DLY_W   = 10,
  localparam int unsigned SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic              ack_in,
  output logic              adc_trig_o,
  output logic              irq_o
);

  logic               cfg_en;
  irq_mode_e          cfg_mode;
  logic [SEL_W-1:0]   cfg_sel;
  logic [RATIO_W-1:0] cfg_ratio;
  logic [DLY_W-1:0]   cfg_dly;
  logic               sel_evt;
  logic               fire;
  logic               irq_pulse;

  evt_trig_cfg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .RATIO_W(RATIO_W), .DLY_W(DLY_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_o(cfg_en), .mode_o(cfg_mode), .sel_o(cfg_sel),
    .ratio_o(cfg_ratio), .dly_o(cfg_dly)
  );

  evt_trig_srcsel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_src (
    .en(cfg_en), .evt_in(evt_in), .sel(cfg_sel), .evt_o(sel_evt)
  );

  evt_trig_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .en(cfg_en), .evt(sel_evt), .dly(cfg_dly),
    .fire_o(fire)
  );

  evt_trig_decim #(.RATIO_W(RATIO_W)) u_decim (
    .clk(clk), .rst(rst), .en(cfg_en), .mode(cfg_mode), .ratio(cfg_ratio),
    .fire(fire), .ack(ack_in), .irq_o(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_trig_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      adc_trig_o <= cfg_en && fire;
      irq_o      <= cfg_en && irq_pulse;
    end
  end

endmodule

// File: rtl/evt_trig_sel_chk.sv
module evt_trig_sel_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned RATIO_W = 16,
  parameter int unsigned DLY_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               ack_mode,
  input logic [SEL_W-1:0]   sel,
  input logic [RATIO_W-1:0] ratio,
  input logic [DLY_W-1:0]   dly,
  input logic [NUM_SRC-1:0] evt_in,
  input logic               ack_in,
  input logic               adc_trig_o,
  input logic               irq_o,
  input logic [RATIO_W-1:0] dec_cnt,
  input logic [DLY_W-1:0]   dly_left,
  input logic               dly_pend
);

  logic [RATIO_W-1:0] n_chk;
  assign n_chk = (ratio == '0) ? RATIO_W'(1) : ratio;

  // R9: disabled block stays silent on the following cycle
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!adc_trig_o && !irq_o));

  // R7: direct-mode interrupt only alongside a trigger
  assert_direct_coincide_R7: assert property (@(posedge clk) disable iff (rst)
    (!ack_mode && irq_o) |-> adc_trig_o);

  // R8: acknowledge-mode interrupt always caused by an acknowledge
  assert_ack_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_mode && irq_o) |-> $past(ack_in));

  // R6: trigger count stays below the ratio
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    en |-> (dec_cnt < n_chk));

  // R4: pending countdown never exceeds the programmed delay
  assert_delay_bound_R4: assert property (@(posedge clk) disable iff (rst)
    dly_pend |-> ((dly_left != '0) && (dly_left <= dly)));

  // R2 / R3: undelayed trigger comes from the selected input only
  assert_route_R2: assert property (@(posedge clk) disable iff (rst)
    (adc_trig_o && ($past(dly) == '0)) |-> $past(evt_in[sel]));

endmodule

bind evt_trig_sel evt_trig_sel_chk #(
  .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .RATIO_W(RATIO_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst(rst), .en(cfg_en), .ack_mode(cfg_mode == evt_trig_pkg::IRQ_ON_ACK),
  .sel(cfg_sel), .ratio(cfg_ratio), .dly(cfg_dly), .evt_in(evt_in),
  .ack_in(ack_in), .adc_trig_o(adc_trig_o), .irq_o(irq_o),
  .dec_cnt(u_decim.cnt_q), .dly_left(u_dly.left_q), .dly_pend(u_dly.pend_q)
);

// File: tb/evt_trig_sel_bench.sv
module evt_trig_sel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  evt_in = '0;
  logic        ack_in = 1'b0;
  logic        adc_trig_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int adc_seen = 0;
  int irq_seen = 0;
  string adc_tag = "R1";
  string irq_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  evt_trig_sel u_evt_trig_sel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt_in(evt_in), .ack_in(ack_in),
    .adc_trig_o(adc_trig_o), .irq_o(irq_o)
  );

  // ---------------- bench model of the requirements ----------------
  logic        m_en, m_mode, m_pend, m_flag, e_adc, e_irq;
  logic [2:0]  m_sel;
  logic [15:0] m_n, m_cnt;
  logic [9:0]  m_d, m_left;

  function automatic logic model_fire(logic sel_hit, logic [9:0] d,
                                      logic pend, logic [9:0] left);
    if (d == 0) return sel_hit;
    return pend && (left == 1) && !sel_hit;
  endfunction

  always @(posedge clk) begin
    logic se, f, last;
    logic [15:0] ne;
    if (rst) begin
      m_en <= 0; m_mode <= 0; m_sel <= 0; m_n <= 1; m_d <= 0;
      m_cnt <= 0; m_pend <= 0; m_left <= 0; m_flag <= 0;
      e_adc <= 0; e_irq <= 0;
    end else begin
      se   = m_en && evt_in[m_sel];
      f    = model_fire(se, m_d, m_pend, m_left);
      ne   = (m_n == 0) ? 16'd1 : m_n;
      last = f && (m_cnt == ne - 16'd1);
      e_adc <= f;
      e_irq <= m_mode ? (m_en && ack_in && m_flag) : last;
      if (!m_en) begin
        m_pend <= 0; m_left <= 0; m_cnt <= 0; m_flag <= 0;
      end else begin
        if (se) begin
          m_left <= m_d; m_pend <= (m_d != 0);
        end else if (m_pend) begin
          m_left <= m_left - 10'd1; m_pend <= (m_left != 1);
        end
        if (f) m_cnt <= last ? 16'd0 : m_cnt + 16'd1;
        m_flag <= m_mode && ((m_flag && !ack_in) || last);
      end
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: begin m_en <= cfg_wdata[0]; m_mode <= cfg_wdata[1]; end
          4'd1: m_sel <= cfg_wdata[2:0];
          4'd2: m_n   <= cfg_wdata[15:0];
          4'd3: m_d   <= cfg_wdata[9:0];
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    n_cmp++;
    if (adc_trig_o !== e_adc) begin
      n_bad++;
      $display("FAIL %s adc_trig_o actual=%b expected=%b t=%0t", adc_tag, adc_trig_o, e_adc, $time);
    end
    n_cmp++;
    if (irq_o !== e_irq) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b t=%0t", irq_tag, irq_o, e_irq, $time);
    end
    if (adc_trig_o === 1'b1) adc_seen++;
    if (irq_o === 1'b1) irq_seen++;
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    step();
    cfg_we = 0;
  endtask

  task automatic setup(input int sel, input int n, input int d, input int mode);
    wr(0, 0); wr(1, sel); wr(2, n); wr(3, d); wr(0, 1 | (mode << 1));
  endtask

  task automatic pulse(input int idx);
    evt_in = 8'(1 << idx); step(); evt_in = '0;
  endtask

  task automatic ack();
    ack_in = 1; step(); ack_in = 0;
  endtask

  task automatic latency(input int idx, output int l);
    evt_in = 8'(1 << idx); step(); evt_in = '0;
    l = 1;
    while (adc_trig_o !== 1'b1 && l < 3000) begin step(); l++; end
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int l;
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) step();
    chk(adc_trig_o, 0, "R1", "adc in reset");
    chk(irq_o, 0, "R1", "irq in reset");
    rst = 0;
    step();

    // R1: disabled by default, events ignored
    adc_tag = "R1"; irq_tag = "R1";
    adc_seen = 0; irq_seen = 0;
    pulse(0); idle(3);
    chk(adc_seen, 0, "R1", "default disabled adc count");
    wr(0, 1);
    latency(0, l);
    chk(l, 1, "R1", "default delay 0 latency");
    chk(irq_o, 1, "R1", "default ratio 1 irq with trigger");
    idle(2);

    // R2: only the selected input routes
    adc_tag = "R2"; irq_tag = "R2";
    setup(3, 1, 0, 0);
    adc_seen = 0;
    pulse(5); pulse(2); evt_in = 8'hF7; step(); evt_in = '0; idle(3);
    chk(adc_seen, 0, "R2", "unselected inputs adc count");
    latency(3, l);
    chk(l, 1, "R2", "selected input latency");

    // R3: zero delay latency, every selectable source
    adc_tag = "R3"; irq_tag = "R3";
    for (int s = 0; s < 8; s++) begin
      setup(s, 1, 0, 0);
      latency(s, l);
      chk(l, 1, "R3", "zero delay latency");
      step();
      chk(adc_trig_o, 0, "R3", "single-cycle pulse");
    end

    // R4: programmed delays incl. the maximum
    adc_tag = "R4"; irq_tag = "R4";
    setup(1, 1, 7, 0);
    latency(1, l);
    chk(l, 8, "R4", "delay 7 latency");
    setup(1, 1, 1023, 0);
    latency(1, l);
    chk(l, 1024, "R4", "delay 1023 latency");
    step();
    chk(adc_trig_o, 0, "R4", "delayed pulse width");

    // R5: retrigger restarts, earlier dropped
    adc_tag = "R5"; irq_tag = "R5";
    setup(1, 1, 10, 0);
    adc_seen = 0;
    pulse(1); idle(3);
    latency(1, l);
    chk(l, 11, "R5", "latency from restarting event");
    idle(15);
    chk(adc_seen, 1, "R5", "single trigger after retrigger");

    // R6: every 5th trigger; ratio 0 acts as 1
    adc_tag = "R6"; irq_tag = "R6";
    setup(1, 5, 0, 0);
    adc_seen = 0; irq_seen = 0;
    for (int k = 0; k < 25; k++) begin pulse(1); idle(9); end
    chk(adc_seen, 25, "R6", "trigger count ratio 5");
    chk(irq_seen, 5, "R6", "irq count ratio 5");
    setup(1, 0, 0, 0);
    irq_seen = 0;
    for (int k = 0; k < 6; k++) begin pulse(1); idle(2); end
    chk(irq_seen, 6, "R6", "irq count ratio 0");

    // R7: direct mode coincidence with delay
    adc_tag = "R7"; irq_tag = "R7";
    setup(4, 2, 3, 0);
    pulse(4); idle(5);
    latency(4, l);
    chk(l, 4, "R7", "second trigger latency");
    chk(irq_o, 1, "R7", "irq with eligible trigger");

    // R8: acknowledge mode
    adc_tag = "R8"; irq_tag = "R8";
    setup(2, 2, 0, 1);
    irq_seen = 0;
    ack(); idle(2);
    chk(irq_seen, 0, "R8", "ack without pending flag");
    pulse(2); idle(2); ack(); idle(2);
    chk(irq_seen, 0, "R8", "ack after non-eligible trigger");
    pulse(2); idle(2);
    chk(irq_seen, 0, "R8", "no irq before ack");
    pulse(2); idle(2); pulse(2); idle(2);
    ack();
    chk(irq_o, 1, "R8", "irq the cycle after ack");
    idle(2); ack(); idle(2);
    chk(irq_seen, 1, "R8", "several eligible triggers give one irq");

    // R9: disable discards pending trigger and count
    adc_tag = "R9"; irq_tag = "R9";
    setup(1, 3, 20, 0);
    adc_seen = 0;
    pulse(1); idle(5); wr(0, 0); idle(30);
    chk(adc_seen, 0, "R9", "pending trigger dropped by disable");
    setup(1, 3, 0, 0);
    irq_seen = 0;
    pulse(1); pulse(1); wr(0, 0); wr(0, 1);
    pulse(1); pulse(1); idle(2);
    chk(irq_seen, 0, "R9", "count restarted after disable");
    pulse(1); idle(2);
    chk(irq_seen, 1, "R9", "third trigger after re-enable");

    // random configurations, scored by the model every cycle
    for (int c = 0; c < 24; c++) begin
      int sel, n, d, mode;
      sel  = $urandom % 8;
      n    = $urandom % 7;
      d    = ($urandom % 3 == 0) ? 0 : ($urandom % 41);
      mode = $urandom % 2;
      adc_tag = (d == 0) ? "R3" : "R5";
      irq_tag = mode ? "R8" : "R7";
      setup(sel, n, d, mode);
      for (int k = 0; k < 800; k++) begin
        evt_in = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
        ack_in = ($urandom % 6 == 0);
        step();
      end
      evt_in = '0; ack_in = 0;
      idle(50);
    end

    idle(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule